// File: doc/BRIEF.md
# Carry-Free Decimal Signed-Digit Adder

This block adds two decimal numbers held in signed-digit form. Every digit occupies a four-bit two's-complement field and takes a value between -6 and +6. Because this digit set holds more values than the radix needs, each position settles its own transfer from its own two operand digits. A transfer therefore moves at most one position upward, and the add delay stays the same for any operand length.

The block returns a sum of the same length plus one outgoing transfer digit. It also reports the sign of the result, taken from the most significant non-zero digit, and reports whether the result is zero. A subtract control negates the second operand digit by digit before the add. Any operand digit whose pattern lies outside the legal set raises an error flag. By default the outputs are registered one clock after the inputs. A parameter can select a purely combinational output instead.

Top module: `sd_dec_adder`

## Requirements
- R1: Digit i of a_i, b_i and sum_o sits in bits [4i+3:4i] as a 4-bit two's-complement value. With legal operands, every sum digit lies in -6..+6.
- R2: With legal operands, value(sum_o) + T·10^K equals value(a_i) + value(b_i) when sub_i=0, and value(a_i) − value(b_i) when sub_i=1. Here value(v) = Σ digit_i·10^i, K is the digit count and T is the transfer digit.
- R3: Each position forms z = x + y. When z ≥ 6 it sends +1 upward and keeps z−10. When z ≤ −6 it sends −1 and keeps z+10. Otherwise it sends 0 and keeps z. xfer_o carries the top position's transfer, encoded 2'b00=0, 2'b01=+1, 2'b11=−1.
- R4: No transfer enters digit 0, so sum digit 0 equals the kept value of position 0 alone. Every higher sum digit equals its kept value plus the transfer from the position below.
- R5: When sub_i=1, every digit of b_i is negated on its own before the add.
- R6: neg_o is 1 exactly when the most significant non-zero digit among {transfer, sum digits} is negative.
- R7: zero_o is 1 exactly when the transfer and all sum digits are zero.
- R8: err_o is 1 when any digit of a_i or b_i has the pattern 4'b0111, 4'b1000 or 4'b1001.
- R9: The outputs change only at a rising clock edge, one cycle after the inputs. While reset is held they read sum 0, transfer 0, neg_o 0, zero_o 1, err_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_i | input | 1 | 1 = subtract b_i from a_i |
| a_i | input | 4·NDIG | First operand, signed digits |
| b_i | input | 4·NDIG | Second operand, signed digits |
| sum_o | output | 4·NDIG | Sum digits |
| xfer_o | output | 2 | Outgoing transfer digit |
| neg_o | output | 1 | Result is negative |
| zero_o | output | 1 | Result is zero |
| err_o | output | 1 | An operand digit is illegal |

## Verification
A wrong transfer decision in a single slice changes the decoded sum by an exact multiple of 10^i. It often also pushes a neighbouring digit out of range. Both effects appear on the registered outputs one edge after the operands are applied. A fault in the sign or zero scan shows as flags that disagree with the sign of the integer sum, or that contradict each other, in that same cycle. A faulty negation path shows up only on subtract vectors, as a wrong result, again after one edge.

// File: rtl/sd_dec_pkg.sv
package sd_dec_pkg;

   // transfer digit code, shared between slices and the top port
   typedef enum logic [1:0] {
      XF_ZERO = 2'b00,
      XF_POS  = 2'b01,
      XF_NEG  = 2'b11
   } xfer_e;

endpackage

// File: rtl/sd_digit_slice.sv
module sd_digit_slice
   import sd_dec_pkg::*;
#(
   parameter int DW    = 4,
   parameter int RADIX = 10,
   parameter int BOUND = 6
) (
   input  logic [DW-1:0] x_i,
   input  logic [DW-1:0] y_i,
   input  xfer_e         t_in,
   output xfer_e         t_out,
   output logic [DW-1:0] s_o,
   output logic          bad_o
);
   localparam int ZW = DW + 1;
   localparam logic signed [ZW-1:0] BND = ZW'(BOUND);
   localparam logic signed [ZW-1:0] RDX = ZW'(RADIX);
   localparam logic signed [DW-1:0] BD  = DW'(BOUND);

   logic signed [ZW-1:0] z;
   logic signed [ZW-1:0] w;
   logic signed [ZW-1:0] tin_ext;
   logic [1:0]           tin_bits;

   // position sum, one bit wider than a digit
   always_comb begin
      z = $signed({x_i[DW-1], x_i}) + $signed({y_i[DW-1], y_i});
   end

   // transfer decision uses only this position's operands
   always_comb begin
      if (z >= BND) begin
         t_out = XF_POS;
         w     = z - RDX;
      end else if (z <= -BND) begin
         t_out = XF_NEG;
         w     = z + RDX;
      end else begin
         t_out = XF_ZERO;
         w     = z;
      end
   end

   // incoming transfer folded in; no further propagation
   always_comb begin
      tin_bits = t_in;
      tin_ext  = {{(ZW-1){tin_bits[1]}}, tin_bits[0]};
      s_o      = DW'(w + tin_ext);
   end

   // legality of the operand digits
   always_comb begin
      bad_o = ($signed(x_i) > BD) || ($signed(x_i) < -BD) ||
              ($signed(y_i) > BD) || ($signed(y_i) < -BD);
   end

endmodule

// File: rtl/sd_digit_negate.sv
module sd_digit_negate #(
   parameter int NDIG = 8,
   parameter int DW   = 4
) (
   input  logic                 en_i,
   input  logic [NDIG*DW-1:0]   d_i,
   output logic [NDIG*DW-1:0]   d_o
);
   for (genvar g = 0; g < NDIG; g++) begin : g_neg
      logic [DW-1:0] dig;
      assign dig = d_i[g*DW +: DW];
      assign d_o[g*DW +: DW] = en_i ? ((~dig) + DW'(1)) : dig;
   end
endmodule

// File: rtl/sd_sign_zero.sv
module sd_sign_zero #(
   parameter int ND = 9,
   parameter int DW = 4
) (
   input  logic [ND*DW-1:0] d_i,
   output logic             neg_o,
   output logic             zero_o
);
   logic found;

   // scan from the most significant digit for the first non-zero one
   always_comb begin
      found = 1'b0;
      neg_o = 1'b0;
      for (int i = ND - 1; i >= 0; i--) begin
         if (!found && (d_i[i*DW +: DW] != '0)) begin
            found = 1'b1;
            neg_o = d_i[i*DW + DW - 1];
         end
      end
      zero_o = !found;
   end
endmodule

// File: rtl/sd_dec_adder.sv
module sd_dec_adder
   import sd_dec_pkg::*;
#(
   parameter int NDIG    = 8,
   parameter int DW      = 4,
   parameter int RADIX   = 10,
   parameter int BOUND   = 6,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sub_i,
   input  logic [NDIG*DW-1:0]  a_i,
   input  logic [NDIG*DW-1:0]  b_i,
   output logic [NDIG*DW-1:0]  sum_o,
   output logic [1:0]          xfer_o,
   output logic                neg_o,
   output logic                zero_o,
   output logic                err_o
);
   localparam int VW = NDIG * DW;
   localparam int SZ = NDIG + 1;
   localparam logic signed [DW-1:0] BD = DW'(BOUND);

   // elaboration-time parameter checks
   if (NDIG < 1) begin : g_chk_ndig
      $error("sd_dec_adder: NDIG must be at least 1");
   end
   if ((RADIX % 2) != 0) begin : g_chk_even
      $error("sd_dec_adder: only even radices are supported");
   end
   if (BOUND < RADIX / 2 + 1) begin : g_chk_lo
      $error("sd_dec_adder: BOUND too small for carry-free addition");
   end
   if (BOUND > RADIX - 1) begin : g_chk_hi
      $error("sd_dec_adder: BOUND exceeds RADIX-1");
   end
   if (BOUND > (2 ** (DW - 1)) - 1) begin : g_chk_dw
      $error("sd_dec_adder: DW cannot hold +/-BOUND");
   end

   logic [VW-1:0]    b_eff;
   logic [VW-1:0]    sum_c;
   logic [NDIG-1:0]  bad_c;
   xfer_e            t_chain [0:NDIG];
   logic             neg_c;
   logic             zero_c;
   logic             err_c;
   logic [1:0]       xfer_bits;
   logic [SZ*DW-1:0] scan_vec;

   sd_digit_negate #(.NDIG(NDIG), .DW(DW)) u_neg (
      .en_i (sub_i),
      .d_i  (b_i),
      .d_o  (b_eff)
   );

   // nothing enters the least significant position
   assign t_chain[0] = XF_ZERO;

   for (genvar g = 0; g < NDIG; g++) begin : g_slice
      sd_digit_slice #(.DW(DW), .RADIX(RADIX), .BOUND(BOUND)) u_sl (
         .x_i   (a_i[g*DW +: DW]),
         .y_i   (b_eff[g*DW +: DW]),
         .t_in  (t_chain[g]),
         .t_out (t_chain[g+1]),
         .s_o   (sum_c[g*DW +: DW]),
         .bad_o (bad_c[g])
      );
   end

   assign err_c     = |bad_c;
   assign xfer_bits = t_chain[NDIG];
   assign scan_vec  = {{(DW-1){xfer_bits[1]}}, xfer_bits[0], sum_c};

   sd_sign_zero #(.ND(SZ), .DW(DW)) u_sz (
      .d_i    (scan_vec),
      .neg_o  (neg_c),
      .zero_o (zero_c)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sum_o  <= '0;
            xfer_o <= XF_ZERO;
            neg_o  <= 1'b0;
            zero_o <= 1'b1;
            err_o  <= 1'b0;
         end else begin
            sum_o  <= sum_c;
            xfer_o <= xfer_bits;
            neg_o  <= neg_c;
            zero_o <= zero_c;
            err_o  <= err_c;
         end
      end
   end else begin : g_comb
      assign sum_o  = sum_c;
      assign xfer_o = xfer_bits;
      assign neg_o  = neg_c;
      assign zero_o = zero_c;
      assign err_o  = err_c;
   end

   // R3
   xfer_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_o != 2'b10);

   // R6
   sign_zero_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(neg_o && zero_o));

   // R6
   neg_xfer_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_o == 2'b11) |-> neg_o);

   // R7
   zero_means_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zero_o |-> ((sum_o == '0) && (xfer_o == 2'b00)));

   for (genvar g = 0; g < NDIG; g++) begin : g_rng
      // R1
      digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !err_o |-> (($signed(sum_o[g*DW +: DW]) <= BD) &&
                     ($signed(sum_o[g*DW +: DW]) >= -BD)));
   end

endmodule

// File: tb/sd_dec_adder_test.sv
module sd_dec_adder_test;
   localparam int N = 8;
   localparam int W = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           sub = 1'b0;
   logic [N*W-1:0] a = '0;
   logic [N*W-1:0] b = '0;
   logic [N*W-1:0] sum_o;
   logic [1:0]     xfer_o;
   logic           neg_o, zero_o, err_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   sd_dec_adder #(.NDIG(N), .DW(W), .RADIX(10), .BOUND(6), .OUT_REG(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .sub_i(sub), .a_i(a), .b_i(b),
      .sum_o(sum_o), .xfer_o(xfer_o), .neg_o(neg_o), .zero_o(zero_o), .err_o(err_o)
   );

   function automatic longint p10(int e);
      longint r = 1;
      for (int i = 0; i < e; i++) r = r * 10;
      return r;
   endfunction

   function automatic longint dig(logic [N*W-1:0] v, int i);
      logic signed [W-1:0] d;
      d = v[i*W +: W];
      return longint'(d);
   endfunction

   function automatic longint dec(logic [N*W-1:0] v);
      longint s = 0;
      for (int i = 0; i < N; i++) s = s + dig(v, i) * p10(i);
      return s;
   endfunction

   function automatic logic [N*W-1:0] enc(longint v);
      logic [N*W-1:0] r = '0;
      longint rest = v;
      for (int i = 0; i < N; i++) begin
         longint d = ((rest % 10) + 10) % 10;
         if (d > 5) d = d - 10;
         r[i*W +: W] = W'(d);
         rest = (rest - d) / 10;
      end
      return r;
   endfunction

   function automatic logic [N*W-1:0] put(int pos, int val);
      logic [N*W-1:0] r = '0;
      r[pos*W +: W] = W'(val);
      return r;
   endfunction

   function automatic longint xval(logic [1:0] x);
      if (x == 2'b01) return 1;
      if (x == 2'b11) return -1;
      return 0;
   endfunction

   task automatic chk(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(logic [N*W-1:0] av, logic [N*W-1:0] bv, logic s);
      @(negedge clk);
      a = av; b = bv; sub = s;
      @(negedge clk);
   endtask

   task automatic check_sum();
      longint exp, act;
      int bad = 0;
      exp = dec(a) + (sub ? -dec(b) : dec(b));
      act = dec(sum_o) + xval(xfer_o) * p10(N);
      chk(act == exp, "R2 value", act, exp);
      for (int i = 0; i < N; i++)
         if (dig(sum_o, i) > 6 || dig(sum_o, i) < -6) bad++;
      chk(bad == 0, "R1 digit range", bad, 0);
      chk(neg_o == (exp < 0), "R6 sign", neg_o, exp < 0);
      chk(zero_o == (exp == 0), "R7 zero", zero_o, exp == 0);
      chk(err_o == 1'b0, "R8 no error", err_o, 0);
   endtask

   task automatic t_reset();
      chk(sum_o == '0, "R9 reset sum", dec(sum_o), 0);
      chk(xfer_o == 2'b00, "R9 reset xfer", xfer_o, 0);
      chk(zero_o == 1'b1 && neg_o == 1'b0 && err_o == 1'b0, "R9 reset flags",
          {zero_o, neg_o, err_o}, 3'b100);
   endtask

   task automatic t_latency();
      @(negedge clk);
      a = enc(123); b = '0; sub = 1'b0;
      #1;
      chk(sum_o == '0, "R9 no early change", dec(sum_o), 0);
      @(negedge clk);
      chk(dec(sum_o) == 123, "R9 one-cycle result", dec(sum_o), 123);
   endtask

   task automatic t_transfer();
      drive(put(0, 3), put(0, 3), 1'b0);
      chk(dig(sum_o, 0) == -4, "R4 digit0 kept only", dig(sum_o, 0), -4);
      chk(dig(sum_o, 1) == 1, "R3 +1 transfer", dig(sum_o, 1), 1);
      drive(put(0, 2), put(0, 3), 1'b0);
      chk(dig(sum_o, 0) == 5 && dig(sum_o, 1) == 0, "R3 z=5 no transfer",
          dig(sum_o, 0), 5);
      drive(put(0, -3), put(0, -3), 1'b0);
      chk(dig(sum_o, 0) == 4, "R3 z=-6 kept", dig(sum_o, 0), 4);
      chk(dig(sum_o, 1) == -1, "R3 -1 transfer", dig(sum_o, 1), -1);
      drive(put(N-1, 6), put(N-1, 6), 1'b0);
      chk(xfer_o == 2'b01, "R3 top xfer +1", xfer_o, 1);
      chk(dig(sum_o, N-1) == 2, "R3 top digit", dig(sum_o, N-1), 2);
      check_sum();
      drive(put(N-1, -6), put(N-1, -6), 1'b0);
      chk(xfer_o == 2'b11, "R3 top xfer -1", xfer_o, 3);
      chk(neg_o == 1'b1, "R6 negative xfer", neg_o, 1);
      drive({N{4'd5}}, {N{4'd1}}, 1'b0);
      chk(dig(sum_o, 0) == -4, "R4 digit0 no incoming", dig(sum_o, 0), -4);
      chk(dig(sum_o, 3) == -3, "R4 upper digit gets incoming", dig(sum_o, 3), -3);
      check_sum();
   endtask

   task automatic t_sub();
      drive(enc(5000), enc(1234), 1'b1);
      chk(dec(sum_o) == 3766, "R5 subtract", dec(sum_o), 3766);
      drive(enc(-4321987), enc(-4321987), 1'b1);
      chk(zero_o == 1'b1 && sum_o == '0, "R5 a-a zero", dec(sum_o), 0);
      drive('0, {N{4'b1010}}, 1'b1);
      check_sum();
      drive(enc(77), enc(1000), 1'b1);
      check_sum();
   endtask

   task automatic t_sign();
      drive(put(3, -1) | put(0, 5), '0, 1'b0);
      chk(neg_o == 1'b1, "R6 msd negative", neg_o, 1);
      chk(dec(sum_o) == -995, "R2 mixed digits", dec(sum_o), -995);
      drive(put(3, 1) | put(0, -5), '0, 1'b0);
      chk(neg_o == 1'b0 && zero_o == 1'b0, "R6 msd positive", neg_o, 0);
      drive(enc(42), enc(-42), 1'b0);
      chk(zero_o == 1'b1, "R7 sum zero", zero_o, 1);
   endtask

   task automatic t_error();
      drive(put(2, 7), '0, 1'b0);
      chk(err_o == 1'b1, "R8 pattern 0111", err_o, 1);
      drive('0, put(0, 8), 1'b0);
      chk(err_o == 1'b1, "R8 pattern 1000", err_o, 1);
      drive('0, put(5, 9), 1'b1);
      chk(err_o == 1'b1, "R8 pattern 1001", err_o, 1);
      drive(put(1, -6), put(4, 6), 1'b0);
      chk(err_o == 1'b0, "R8 legal bounds", err_o, 0);
   endtask

   task automatic t_random();
      for (int k = 0; k < 300; k++) begin
         logic [N*W-1:0] av, bv;
         for (int i = 0; i < N; i++) begin
            av[i*W +: W] = W'(int'($urandom_range(12)) - 6);
            bv[i*W +: W] = W'(int'($urandom_range(12)) - 6);
         end
         drive(av, bv, 1'($urandom_range(1)));
         check_sum();
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_latency();
      t_transfer();
      t_sub();
      t_sign();
      t_error();
      t_random();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule